// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one general-purpose I/O port of `WIDTH` pins (eight by default). Software reaches it over a small register bus. Through that bus it programs three registers: an output data latch, a per-pin direction register and a per-pin pull-up enable register. On the pad side, the block drives an output value, an output enable and a pull-up request for each pin. It takes back the raw pad level, which passes through a two-flop synchronizer before any logic uses it.

Any pin can be lent to an on-chip peripheral through a per-pin alternate-select input. While a pin is lent, the peripheral's own output value and output enable drive the pad, and the direction register and data latch for that pin have no say. The latch keeps the value software last wrote to it, so the pin returns to software control unchanged when the select drops.

Reads of the data offset do not return the same thing for every pin. An output pin returns the latch, so an externally loaded pin still reads back the value software intended. An input pin returns the synchronized pad level. Pull-ups are only requested on pins that are not being driven.

Top module: `gpio_port_ctrl`

## Requirements
- R1: When reset is released, the data latch, direction and pull-up registers are all zero, and pad_out, pad_oe and pad_pu are all zero, so every pin starts as an undriven input.
- R2: A cycle with bus_sel=1 and bus_wr=1 writes bus_wdata on that rising edge. Offset 0 is the data latch, offset 1 is the direction register (1 = output, 0 = input) and offset 2 is the pull-up enable register (1 = enabled). The new value is visible on reads and pins right after that edge, and reads of offsets 1 and 2 return the stored register.
- R3: For a pin with alt_sel=0, pad_oe equals its direction bit and pad_out equals its data latch bit.
- R4: A read of offset 0 returns the data latch bit for every pin whose direction bit is 1, whatever the pad level.
- R5: A read of offset 0 returns the pad level for every pin whose direction bit is 0. A pad change becomes visible after exactly two rising clock edges.
- R6: Writing the data latch while a pin is an input stores the value but leaves pad_oe at 0. The stored value appears once the pin is made an output.
- R7: For a pin with alt_sel=1, pad_oe equals alt_oe and pad_out equals alt_out, whatever the direction and latch bits hold.
- R8: Lending a pin to a peripheral never alters its data latch. When alt_sel returns to 0, pad_out shows the latch again.
- R9: pad_pu is 1 exactly when the pin's pull-up enable is 1 and its effective output enable (pad_oe) is 0.
- R10: Offset 3 reads as zero, and a write to offset 3 changes no register. A cycle with bus_wr=1 but bus_sel=0 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register offset for read and write |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| alt_sel | input | WIDTH | Per-pin hand-over to a peripheral |
| alt_out | input | WIDTH | Peripheral output value |
| alt_oe | input | WIDTH | Peripheral output enable |
| pad_in | input | WIDTH | Raw pad level, asynchronous |
| pad_out | output | WIDTH | Value to drive onto each pad |
| pad_oe | output | WIDTH | Per-pad driver enable |
| pad_pu | output | WIDTH | Per-pad pull-up request |

## Verification
The assertions assume a clean register bus: bus_addr, bus_wdata, bus_sel and bus_wr settle before each rising edge and stay steady through it. They also assume the pad input is only compared through the synchronized copy, never the raw pad. The bench drives every bus and pad input on the falling edge and holds pad_in constant during each sweep, so the synchronized value has settled before any read that depends on it. The exception is the latency check, where pad_in changes once and the read is sampled edge by edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 2;

    // Register offsets; the bench and software rely on this map.
    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_PULL = 2'd2,
        REG_NONE = 2'd3
    } gpio_reg_e;

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_reg_e        wr_reg,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pu_q
);

    logic wr_lat;
    logic wr_dir;
    logic wr_pu;

    always_comb begin
        wr_lat = 1'b0;
        wr_dir = 1'b0;
        wr_pu  = 1'b0;
        unique case (wr_reg)
            REG_DATA: wr_lat = wr_en;
            REG_DIR:  wr_dir = wr_en;
            REG_PULL: wr_pu  = wr_en;
            REG_NONE: ;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            dir_q <= '0;
            pu_q  <= '0;
        end else begin
            if (wr_lat) lat_q <= wr_data;
            if (wr_dir) dir_q <= wr_data;
            if (wr_pu)  pu_q  <= wr_data;
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pu_q,
    input  logic [WIDTH-1:0] alt_sel,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic oe_eff;
        assign oe_eff     = alt_sel[i] ? alt_oe[i]  : dir_q[i];
        assign pad_oe[i]  = oe_eff;
        assign pad_out[i] = alt_sel[i] ? alt_out[i] : lat_q[i];
        assign pad_pu[i]  = pu_q[i] & ~oe_eff;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  alt_sel,
    input  logic [WIDTH-1:0]  alt_out,
    input  logic [WIDTH-1:0]  alt_oe,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);

    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pu_q;
    logic [WIDTH-1:0] sync_q;
    gpio_reg_e        reg_sel;

    assign reg_sel = gpio_reg_e'(bus_addr);

    gpio_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_sel & bus_wr),
        .wr_reg  (reg_sel),
        .wr_data (bus_wdata),
        .lat_q   (lat_q),
        .dir_q   (dir_q),
        .pu_q    (pu_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .lat_q   (lat_q),
        .dir_q   (dir_q),
        .pu_q    (pu_q),
        .alt_sel (alt_sel),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    // Readback: output pins return the latch, input pins the synced pad.
    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel)
            REG_DATA: bus_rdata = (lat_q & dir_q) | (sync_q & ~dir_q);
            REG_DIR:  bus_rdata = dir_q;
            REG_PULL: bus_rdata = pu_q;
            REG_NONE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_ctrl_checker.sv
module gpio_port_ctrl_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] lat_q,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] pu_q,
    input logic [WIDTH-1:0] sync_q
);

    p_write_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd0) |=> (lat_q == $past(bus_wdata)));

    p_write_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> (dir_q == $past(bus_wdata)));

    p_write_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd2) |=> (pu_q == $past(bus_wdata)));

    p_out_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (((bus_rdata ^ lat_q) & dir_q) == '0));

    p_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (((bus_rdata ^ sync_q) & ~dir_q) == '0));

    p_pull_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_sel && bus_wr) || bus_addr == 2'd3)
            |=> ($stable(lat_q) && $stable(dir_q) && $stable(pu_q)));

    p_spare_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == '0));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .lat_q     (lat_q),
    .dir_q     (dir_q),
    .pu_q      (pu_q),
    .sync_q    (sync_q)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] alt_sel = '0;
    logic [W-1:0] alt_out = '0;
    logic [W-1:0] alt_oe = '0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_pu;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt_sel(alt_sel), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [W-1:0] r;
        logic [W-1:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_out", pad_out, '0);
        check("R1 pad_pu", pad_pu, '0);
        rd(2'd1, r); check("R1 dir", r, '0);
        rd(2'd2, r); check("R1 pull", r, '0);
        wr(2'd1, 8'hFF); rd(2'd0, r); check("R1 latch", r, '0);

        // Sweep all direction values with a fixed pad pattern
        p = 8'hC6;
        pad_in = p;
        for (int d = 0; d < 256; d++) begin
            logic [W-1:0] dv, lv, uv;
            dv = W'(d); lv = dv ^ 8'h5A; uv = ~(dv + 8'h13);
            wr(2'd1, dv); wr(2'd0, lv); wr(2'd2, uv);
            rd(2'd1, r); check("R2 dir readback", r, dv);
            rd(2'd2, r); check("R2 pull readback", r, uv);
            check("R3 pad_oe", pad_oe, dv);
            check("R3 pad_out", pad_out, lv);
            check("R9 pad_pu", pad_pu, uv & ~dv);
            rd(2'd0, r); check("R4 R5 data read", r, (lv & dv) | (p & ~dv));
        end

        // R5 latency: two edges from pad change to readback
        wr(2'd1, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hFF;
        rd(2'd0, r); check("R5 before edge", r, 8'h00);
        @(negedge clk); rd(2'd0, r); check("R5 one edge", r, 8'h00);
        @(negedge clk); rd(2'd0, r); check("R5 two edges", r, 8'hFF);

        // R6 write while input
        wr(2'd0, 8'hA5);
        check("R6 pad_oe stays low", pad_oe, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd0, r); check("R6 latch kept", r, 8'hA5);
        check("R6 pad_out", pad_out, 8'hA5);

        // Alternate function sweep
        wr(2'd1, 8'h0F); wr(2'd0, 8'h33); wr(2'd2, 8'hFF);
        p = 8'h96; pad_in = p;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            logic [W-1:0] sv, ov, ev, oe_x;
            sv = W'(a); ov = ~sv ^ 8'h3C; ev = {sv[2:0], sv[7:3]};
            @(negedge clk);
            alt_sel = sv; alt_out = ov; alt_oe = ev;
            #1;
            oe_x = (sv & ev) | (~sv & 8'h0F);
            check("R7 pad_oe", pad_oe, oe_x);
            check("R7 pad_out", pad_out, (sv & ov) | (~sv & 8'h33));
            check("R9 pad_pu alt", pad_pu, ~oe_x);
            rd(2'd0, r); check("R8 latch under alt", r, (8'h33 & 8'h0F) | (p & 8'hF0));
        end
        @(negedge clk);
        alt_sel = '0;
        wr(2'd1, 8'hFF);
        check("R8 pad_out restored", pad_out, 8'h33);
        rd(2'd0, r); check("R8 latch restored", r, 8'h33);

        // R10 spare offset and unselected writes
        wr(2'd3, 8'hFF);
        rd(2'd3, r); check("R10 spare read", r, 8'h00);
        rd(2'd0, r); check("R10 latch", r, 8'h33);
        rd(2'd1, r); check("R10 dir", r, 8'hFF);
        rd(2'd2, r); check("R10 pull", r, 8'hFF);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(2'd1, r); check("R10 unselected write", r, 8'hFF);
        check("R10 pad_oe", pad_oe, 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule